// File: doc/BRIEF.md
# Dual 16-bit Signed Multiply-Accumulate

This block takes two 32-bit operands. Each operand holds two signed 16-bit halves. The block multiplies the low half of one operand by the low half of the other, and the high half by the high half. It adds both products to a signed 32-bit accumulator operand and returns the low 32 bits of that sum.

The three terms are added at full precision. Overflow is therefore judged once, on the final value. If the two products overflow 32 bits when added together, and the accumulator brings the total back into range, nothing is flagged.

Results are registered one cycle after a valid strobe. Overflow feeds a sticky saturation flag. The flag stays set until a separate synchronous clear input drops it.

Top module: `dmac_dual16`

## Requirements
- R1: The first product is the signed product of `op_a[15:0]` and `op_b[15:0]`, each read as two's complement.
- R2: The second product is the signed product of `op_a[31:16]` and `op_b[31:16]`, each read as two's complement.
- R3: `result` equals bits [31:0] of the exact sum: first product plus second product plus `acc_in`, with `acc_in` read as signed.
- R4: An operation raises the saturation flag only when the exact three-term sum lies outside [-2^31, 2^31-1]. The sum of the two products overflowing 32 bits does not raise the flag by itself. For example, `op_a` = `op_b` = 0x80008000 with `acc_in` = 0xFFFFFFFF gives `result` 0x7FFFFFFF and no flag.
- R5: Once set, `sat_flag` stays 1 through later non-overflowing operations and idle cycles until a clear.
- R6: `sat_clr` drops the flag at the next rising edge. If an overflowing operation is accepted in the same cycle, the flag ends at 1.
- R7: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. `result` and the flag reflect that operation in the same cycle.
- R8: Without `in_valid`, `result` holds its value. Without `in_valid` or `sat_clr`, the flag holds its value.
- R9: With `rst` high at a rising edge, `out_valid`, `result` and `sat_flag` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | 32 | First packed pair of signed halves |
| op_b | input | 32 | Second packed pair of signed halves |
| acc_in | input | 32 | Signed accumulator term |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Low 32 bits of the exact sum |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A sum that is too narrow, or overflow judged on a partial sum, shows up at the ports one cycle after the offending operation. It appears as a wrong `sat_flag` on corner operands that mix 0x8000 and 0x7FFF halves with extreme accumulators. A misdecoded half or an unsigned multiply shows up in `result` in that same cycle. A broken hold or sticky path is exposed on the first idle or clear-only cycle that follows a set flag.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // Number of multiplier lanes packed into each operand word.
  localparam int LANES = 2;

  // Two guard bits above the widest term keep a three-term signed sum exact.
  function automatic int exact_sum_width(input int term_w);
    return term_w + 2;
  endfunction
endpackage

// File: rtl/dmac_lane_mul.sv
module dmac_lane_mul #(
  parameter int HALF_W = 16,
  localparam int PROD_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0]        x,
  input  logic [HALF_W-1:0]        y,
  output logic signed [PROD_W-1:0] p
);
  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] y_ext;

  assign x_ext = {{HALF_W{x[HALF_W-1]}}, x};
  assign y_ext = {{HALF_W{y[HALF_W-1]}}, y};
  assign p     = x_ext * y_ext;
endmodule

// File: rtl/dmac_sum3.sv
module dmac_sum3 #(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 32,
  localparam int SUM_W = dmac_pkg::exact_sum_width((PROD_W > ACC_W) ? PROD_W : ACC_W),
  localparam int TOP_W = SUM_W - ACC_W + 1
) (
  input  logic signed [PROD_W-1:0] pa,
  input  logic signed [PROD_W-1:0] pb,
  input  logic [ACC_W-1:0]         acc,
  output logic [ACC_W-1:0]         sum_lo,
  output logic                     ovf
);
  logic signed [SUM_W-1:0] pa_x;
  logic signed [SUM_W-1:0] pb_x;
  logic signed [SUM_W-1:0] acc_x;
  logic signed [SUM_W-1:0] total;
  logic [TOP_W-1:0]        top_bits;

  assign pa_x  = {{(SUM_W-PROD_W){pa[PROD_W-1]}}, pa};
  assign pb_x  = {{(SUM_W-PROD_W){pb[PROD_W-1]}}, pb};
  assign acc_x = {{(SUM_W-ACC_W){acc[ACC_W-1]}}, acc};
  assign total = pa_x + pb_x + acc_x;

  // The result is representable only if every bit from the result's sign bit up is equal.
  assign top_bits = total[SUM_W-1:ACC_W-1];
  assign sum_lo   = total[ACC_W-1:0];
  assign ovf      = ~((&top_bits) | (~|top_bits));
endmodule

// File: rtl/dmac_sticky.sv
module dmac_sticky (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/dmac_dual16.sv
module dmac_dual16 #(
  parameter int HALF_W = 16,
  localparam int WORD_W = dmac_pkg::LANES * HALF_W,
  localparam int PROD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [WORD_W-1:0] acc_in,
  input  logic              sat_clr,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              sat_flag
);
  logic signed [PROD_W-1:0] prod [dmac_pkg::LANES];
  logic [WORD_W-1:0]        sum_lo;
  logic                     sum_ovf;

  for (genvar g = 0; g < dmac_pkg::LANES; g++) begin : g_lane
    dmac_lane_mul #(.HALF_W(HALF_W)) u_mul (
      .x (op_a[g*HALF_W +: HALF_W]),
      .y (op_b[g*HALF_W +: HALF_W]),
      .p (prod[g])
    );
  end

  dmac_sum3 #(.PROD_W(PROD_W), .ACC_W(WORD_W)) u_sum (
    .pa     (prod[0]),
    .pb     (prod[1]),
    .acc    (acc_in),
    .sum_lo (sum_lo),
    .ovf    (sum_ovf)
  );

  dmac_sticky u_flag (
    .clk (clk),
    .rst (rst),
    .clr (sat_clr),
    .set (in_valid & sum_ovf),
    .q   (sat_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= sum_lo;
    end
  end
endmodule

// File: rtl/dmac_dual16_chk.sv
module dmac_dual16_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic [WORD_W-1:0] acc_in,
  input logic              sat_clr,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic              sat_flag
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    in_valid |=> out_valid);
  assert_no_valid_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    !in_valid |=> !out_valid);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    !in_valid |=> $stable(result));
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    (!in_valid && !sat_clr) |=> $stable(sat_flag));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (sat_flag && !sat_clr) |=> sat_flag);
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    (sat_clr && !in_valid) |=> !sat_flag);
  assert_zero_operand_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (in_valid && (op_a == '0 || op_b == '0)) |=> (result == $past(acc_in)));
  assert_reset_R9: assert property (@(posedge clk) disable iff (!armed)
    rst |=> (!out_valid && !sat_flag && result == '0));
endmodule

bind dmac_dual16 dmac_dual16_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_dmac_dual16.sv
`timescale 1ns/1ps
module sim_dmac_dual16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] acc_in = '0;
  logic        sat_clr = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        sat_flag;

  int checks = 0;
  int failures = 0;
  bit exp_flag = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dmac_dual16 u0 (.*);

  function automatic longint exact_sum(input logic [31:0] a, input logic [31:0] b,
                                       input logic [31:0] c);
    longint p0 = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    longint p1 = longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
    return p0 + p1 + longint'($signed(c));
  endfunction

  function automatic bit out_of_range(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Apply one operation; check outputs one cycle later.
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input bit clr, input string req);
    longint s;
    @(negedge clk);
    op_a = a; op_b = b; acc_in = c; sat_clr = clr; in_valid = 1'b1;
    s = exact_sum(a, b, c);
    exp_flag = (clr ? 1'b0 : exp_flag) | out_of_range(s);
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    chk({req, " valid R7"}, {31'd0, out_valid}, 32'd1);
    chk({req, " result"}, result, s[31:0]);
    chk({req, " flag"}, {31'd0, sat_flag}, {31'd0, exp_flag});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] h [5];
    logic [31:0] accs [4];
    logic [31:0] held;
    void'($urandom(32'd4242));
    h[0] = 16'h8000; h[1] = 16'h7FFF; h[2] = 16'h0000; h[3] = 16'h0001; h[4] = 16'hFFFF;
    accs[0] = 32'h8000_0000; accs[1] = 32'h7FFF_FFFF; accs[2] = 32'h0; accs[3] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 result", result, 32'd0);
    chk("R9 flag", {31'd0, sat_flag}, 32'd0);

    // R1 low halves only, R2 high halves only
    apply(32'h0000_8000, 32'h0000_7FFF, 32'd5, 1'b1, "R1");
    apply(32'h0000_FFFD, 32'h0000_0007, 32'd0, 1'b1, "R1");
    apply(32'h7FFF_0000, 32'h8001_0000, 32'd5, 1'b1, "R2");
    apply(32'hFFFE_0000, 32'h0003_0000, 32'd100, 1'b1, "R2");

    // R4 the recovered intermediate overflow, then a true overflow
    apply(32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 1'b1, "R4");
    chk("R4 recovered result", result, 32'h7FFF_FFFF);
    chk("R4 recovered no flag", {31'd0, sat_flag}, 32'd0);
    apply(32'h8000_8000, 32'h8000_8000, 32'h0, 1'b1, "R4");
    chk("R4 overflow flag", {31'd0, sat_flag}, 32'd1);

    // R5 sticky through idle and through a clean op; R7 idle valid low
    @(negedge clk);
    chk("R7 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R5 sticky idle", {31'd0, sat_flag}, 32'd1);
    apply(32'h0001_0001, 32'h0001_0001, 32'd3, 1'b0, "R5");
    chk("R5 sticky after clean op", {31'd0, sat_flag}, 32'd1);

    // R8 and R6: clear alone drops flag, result held
    held = result;
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    exp_flag = 1'b0;
    chk("R6 clear alone", {31'd0, sat_flag}, 32'd0);
    chk("R8 result held", result, held);
    chk("R7 valid low on clear", {31'd0, out_valid}, 32'd0);
    // R8 inputs change without valid: no effect
    @(negedge clk); op_a = 32'h7FFF_7FFF; op_b = 32'h7FFF_7FFF; acc_in = 32'h7FFF_FFFF;
    @(negedge clk);
    chk("R8 result unchanged", result, held);
    chk("R8 flag unchanged", {31'd0, sat_flag}, 32'd0);

    // R6 clear coincident with overflowing op keeps flag
    apply(32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 1'b1, "R6");
    chk("R6 clear+overflow", {31'd0, sat_flag}, 32'd1);

    // R3/R4 corner sweep
    for (int ia = 0; ia < 5; ia++)
      for (int ib = 0; ib < 5; ib++)
        for (int ic = 0; ic < 4; ic++)
          apply({h[ia], h[ib]}, {h[ib], h[ia]}, accs[ic], 1'b1, "R3 corner");

    // R3/R4/R5 random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b, c;
      a = $urandom(); b = $urandom(); c = $urandom();
      if ($urandom() % 4 == 0) a[15:0] = h[$urandom() % 5];
      if ($urandom() % 4 == 0) b[31:16] = h[$urandom() % 5];
      if ($urandom() % 4 == 0) c = accs[$urandom() % 4];
      apply(a, b, c, ($urandom() % 3) == 0, "R3 random");
    end

    // R9 reset mid-run with flag set
    apply(32'h8000_8000, 32'h8000_8000, 32'h0, 1'b1, "R4");
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    exp_flag = 1'b0;
    chk("R9 mid reset valid", {31'd0, out_valid}, 32'd0);
    chk("R9 mid reset result", result, 32'd0);
    chk("R9 mid reset flag", {31'd0, sat_flag}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule